// File: doc/BRIEF.md
# Full-Duplex I2S Serial Audio Port

This block is a full-duplex serial audio port that hangs off a 16-bit register bus. Software writes left and right transmit words into holding registers. Once per frame, both words are copied into a transmit shifter. The incoming serial stream is captured by a receive shifter, and the two received words are moved into receive holding registers at the same frame boundary. The port is always the clock master. It derives the bit clock and word-select from the system clock, which is treated as the audio reference clock, and it can also pass that reference out on a gated master-clock pin.

Each channel word is 16 or 32 bits, and a 2-bit code sets the frame rate. In 32-bit mode the upper half of each word goes through the main data registers and the lower half through a separate low register per channel. Flags in the control register report, per channel, that a transmit buffer is full and that a receive buffer is full. Two sticky flags report a transmit underrun and a receive overrun. A maskable interrupt output tells software that the port needs service.

Top module: `i2s_port`

## Requirements
- R1: With the port enabled, one bit-clock period lasts 2 system clocks for rate code 2'b10, 4 for 2'b01, and 8 for 2'b00 and 2'b11. The rate code is control bits [5:4].
- R2: A frame has 32 bit clocks when control bit 3 is 0 (16-bit words) and 64 when it is 1 (32-bit words). Data changes on the falling bit-clock edge and is sent MSB first. The left word goes out while ws is low and the right word while ws is high, and ws changes one bit clock before each MSB.
- R3: While the enable bit (control bit 0) is set, a control write leaves the width bit and the rate code unchanged.
- R4: After reset, and whenever the enable bit is clear, bclk, ws and sdout are low. Setting the enable bit starts the frame timing for the transmitter and the receiver together.
- R5: mclk_out follows the system clock while control bit 1 is set, and is low otherwise.
- R6: A write to the left data register (address 1) or right data register (address 2) sets that channel's transmit-full flag (control bit 8 left, bit 9 right). Both flags clear when the buffers are copied into the shifter at the start of a frame.
- R7: If either transmit-full flag is clear at the frame copy, the sticky underrun flag (bit 10) is set and the previous words are sent again. Writing 0 to bit 10 clears the flag, and writing 1 leaves it unchanged.
- R8: At each frame boundary after the first complete frame, the received words move into the receive buffers, and both receive-full flags set (bit 11 left, bit 12 right). A read of address 1 or 2 returns that channel's received upper half and clears that channel's flag only.
- R9: If either receive-full flag is still set at a frame transfer, the sticky overrun flag (bit 13) is set and the receive buffers keep their old words. Writing 0 to bit 13 clears the flag, and writing 1 leaves it unchanged.
- R10: In 32-bit mode, address 3 holds the low 16 bits of the left word and address 4 the low 16 bits of the right word, for both transmit (write) and receive (read).
- R11: irq is high when the port is enabled and the interrupt enable (control bit 2) is set, and at least one of two conditions holds: a transmit-full flag is clear, or both receive-full flags are set. Otherwise irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and audio reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register select: 0 control, 1 left, 2 right, 3 left low, 4 right low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of address 1 or 2 clears that receive-full flag |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| sdin | input | 1 | Serial receive data |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, low for the left channel |
| sdout | output | 1 | Serial transmit data |
| mclk_out | output | 1 | Gated copy of the reference clock |
| irq | output | 1 | Service request |

## Verification
The receive overrun is the hardest case to reach. It needs a full frame to arrive and be transferred, and then another whole frame to land without any read in between. Sending the first frame only primes the receive path. The bench loops sdout back to sdin and streams several transmit frames without reading the receive side. This fills the receive buffers with the first frame, and the next boundary then sets the overrun. Reading both data registers then shows that the first frame's words survived.

// File: rtl/i2s_pkg.sv
// Shared constants and register addresses for the serial audio port.
// Assumes a 16-bit register bus and at most 32 bits per channel word.
package i2s_pkg;
    localparam int BUS_W    = 16;
    localparam int SLOT_MAX = 32;
    localparam int FRAME_MAX = 2 * SLOT_MAX;

    typedef enum logic [2:0] {
        A_CTRL     = 3'd0,
        A_LEFT     = 3'd1,
        A_RIGHT    = 3'd2,
        A_LEFT_LO  = 3'd3,
        A_RIGHT_LO = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/i2s_clkgen.sv
// Master timing: divides the reference clock into bclk and ws and emits
// single-cycle events for the bit-clock edges and the frame boundary.
// Assumes rate and width do not change while en is high.
module i2s_clkgen #(
    parameter int PH_W  = 3,
    parameter int BIT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wide,
    input  logic [1:0] rate,
    output logic       bclk,
    output logic       ws,
    output logic       fall_evt,
    output logic       rise_evt,
    output logic       frame_evt
);
    import i2s_pkg::*;

    logic [PH_W-1:0]  ph, half_m1, last_ph;
    logic [BIT_W-1:0] bitc, last_bit, word_m1, nbit;

    // Decode rate and width into divider and frame limits.
    always_comb begin
        case (rate)
            2'b10:   half_m1 = PH_W'(0);
            2'b01:   half_m1 = PH_W'(1);
            default: half_m1 = PH_W'(3);
        endcase
        last_ph  = {half_m1[PH_W-2:0], 1'b1};
        last_bit = wide ? BIT_W'(FRAME_MAX - 1) : BIT_W'(SLOT_MAX - 1);
        word_m1  = wide ? BIT_W'(SLOT_MAX - 1) : BIT_W'(SLOT_MAX/2 - 1);
        nbit     = (bitc == last_bit) ? '0 : bitc + 1'b1;
        fall_evt  = en && (ph == last_ph);
        rise_evt  = en && (ph == half_m1);
        frame_evt = fall_evt && (bitc == last_bit);
    end

    // Advance phase and bit counters, drive bclk and ws.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph   <= '0;
            bitc <= last_bit;
            bclk <= 1'b0;
            ws   <= 1'b0;
        end else if (fall_evt) begin
            ph   <= '0;
            bitc <= nbit;
            bclk <= 1'b0;
            ws   <= (nbit >= word_m1) && (nbit != last_bit);
        end else begin
            ph <= ph + 1'b1;
            if (rise_evt) bclk <= 1'b1;
        end
    end

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk && !ws));

    // R2
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(ws)) |-> $fell(bclk));
endmodule

// File: rtl/i2s_tx.sv
// Transmit shifter: loads both channel words at the frame boundary and
// shifts MSB first on each falling bit-clock event.
// Assumes 16-bit words sit in the upper halves of left/right.
module i2s_tx #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wide,
    input  logic          fall_evt,
    input  logic          frame_evt,
    input  logic [SW-1:0] left,
    input  logic [SW-1:0] right,
    output logic          sdout
);
    localparam int HW = SW / 2;
    logic [2*SW-1:0] sh;

    // Load or shift the outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            sh <= '0;
        else if (frame_evt)
            sh <= wide ? {left, right} : {left[SW-1:HW], right[SW-1:HW], {SW{1'b0}}};
        else if (fall_evt)
            sh <= {sh[2*SW-2:0], 1'b0};
    end

    assign sdout = sh[2*SW-1];
endmodule

// File: rtl/i2s_rx.sv
// Receive shifter: captures sdin on each rising bit-clock event and presents
// the last frame's two words, with 16-bit words placed in the upper halves.
module i2s_rx #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          rise_evt,
    input  logic          sdin,
    output logic [SW-1:0] left,
    output logic [SW-1:0] right
);
    localparam int HW = SW / 2;
    logic [2*SW-1:0] sh;

    // Shift in one serial bit per rising bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (rise_evt)
            sh <= {sh[2*SW-2:0], sdin};
    end

    assign left  = wide ? sh[2*SW-1:SW] : {sh[SW-1:HW], {HW{1'b0}}};
    assign right = wide ? sh[SW-1:0]    : {sh[HW-1:0],  {HW{1'b0}}};
endmodule

// File: rtl/i2s_port.sv
// Register-bus serial audio port: control/status register, transmit and
// receive holding registers with per-channel full flags, sticky underrun and
// overrun detection at the frame copy, interrupt and gated master clock.
// Assumes one-cycle bus strobes and that the port is always clock master.
module i2s_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        sdin,
    output logic        bclk,
    output logic        ws,
    output logic        sdout,
    output logic        mclk_out,
    output logic        irq
);
    import i2s_pkg::*;
    localparam int HW = SLOT_MAX / 2;

    logic en, mclk_en, irq_en, wide;
    logic [1:0] rate;
    logic [SLOT_MAX-1:0] tx_l, tx_r, rx_l, rx_r, rxs_l, rxs_r;
    logic tx_lf, tx_rf, urun, rx_lf, rx_rf, orun, first;
    logic fall_evt, rise_evt, frame_evt;
    logic wr_ctrl, xfer_ok;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign xfer_ok = frame_evt && !first && !rx_lf && !rx_rf;

    i2s_clkgen #(.PH_W(3), .BIT_W($clog2(FRAME_MAX))) u_clk (
        .clk(clk), .rst_n(rst_n), .en(en), .wide(wide), .rate(rate),
        .bclk(bclk), .ws(ws), .fall_evt(fall_evt), .rise_evt(rise_evt),
        .frame_evt(frame_evt));

    i2s_tx #(.SW(SLOT_MAX)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .wide(wide), .fall_evt(fall_evt),
        .frame_evt(frame_evt), .left(tx_l), .right(tx_r), .sdout(sdout));

    i2s_rx #(.SW(SLOT_MAX)) u_rx (
        .clk(clk), .rst_n(rst_n), .wide(wide), .rise_evt(rise_evt),
        .sdin(sdin), .left(rxs_l), .right(rxs_r));

    // Control fields; width and rate are locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; mclk_en <= 1'b0; irq_en <= 1'b0;
            wide <= 1'b0; rate <= 2'b00;
        end else if (wr_ctrl) begin
            en      <= bus_wdata[0];
            mclk_en <= bus_wdata[1];
            irq_en  <= bus_wdata[2];
            if (!en) begin
                wide <= bus_wdata[3];
                rate <= bus_wdata[5:4];
            end
        end
    end

    // Transmit holding registers, full flags and underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_l <= '0; tx_r <= '0;
            tx_lf <= 1'b0; tx_rf <= 1'b0; urun <= 1'b0;
        end else begin
            if (wr_ctrl && !bus_wdata[10]) urun <= 1'b0;
            if (frame_evt) begin
                tx_lf <= 1'b0;
                tx_rf <= 1'b0;
                if (!tx_lf || !tx_rf) urun <= 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    A_LEFT:     begin tx_l[SLOT_MAX-1:HW] <= bus_wdata; tx_lf <= 1'b1; end
                    A_RIGHT:    begin tx_r[SLOT_MAX-1:HW] <= bus_wdata; tx_rf <= 1'b1; end
                    A_LEFT_LO:  tx_l[HW-1:0] <= bus_wdata;
                    A_RIGHT_LO: tx_r[HW-1:0] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Receive holding registers, full flags, overrun and first-frame skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_l <= '0; rx_r <= '0;
            rx_lf <= 1'b0; rx_rf <= 1'b0; orun <= 1'b0; first <= 1'b1;
        end else begin
            if (!en) first <= 1'b1;
            else if (frame_evt) first <= 1'b0;
            if (wr_ctrl && !bus_wdata[13]) orun <= 1'b0;
            if (bus_rd && (bus_addr == A_LEFT))  rx_lf <= 1'b0;
            if (bus_rd && (bus_addr == A_RIGHT)) rx_rf <= 1'b0;
            if (frame_evt && !first) begin
                if (rx_lf || rx_rf) begin
                    orun <= 1'b1;
                end else begin
                    rx_l <= rxs_l; rx_r <= rxs_r;
                    rx_lf <= 1'b1; rx_rf <= 1'b1;
                end
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            A_CTRL:     bus_rdata = {2'b00, orun, rx_rf, rx_lf, urun, tx_rf, tx_lf,
                                     2'b00, rate, wide, irq_en, mclk_en, en};
            A_LEFT:     bus_rdata = rx_l[SLOT_MAX-1:HW];
            A_RIGHT:    bus_rdata = rx_r[SLOT_MAX-1:HW];
            A_LEFT_LO:  bus_rdata = rx_l[HW-1:0];
            A_RIGHT_LO: bus_rdata = rx_r[HW-1:0];
            default:    bus_rdata = '0;
        endcase
    end

    assign mclk_out = clk & mclk_en;
    assign irq = en && irq_en && (!tx_lf || !tx_rf || (rx_lf && rx_rf));

    // R6
    tx_left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LEFT) |=> tx_lf);

    // R8
    rx_left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LEFT && !xfer_ok) |=> !rx_lf);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (orun && !(wr_ctrl && !bus_wdata[13])) |=> orun);

    // R3
    fmt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable({wide, rate}));
endmodule

// File: tb/i2s_port_bench.sv
// Scoreboard bench: the driver pushes expected frames, the monitor decodes
// sdout into frames and compares; sdin is looped back from sdout.
module i2s_port_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    wire [15:0] bus_rdata;
    wire bclk, ws, sdout, mclk_out, irq, sdin;
    assign sdin = sdout;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] exp_q[$];
    logic [63:0] item;
    int mon_w = 16;
    logic mon_prev_ws = 1'b0, mon_prev_bclk = 1'b0;
    logic [63:0] mon_sh = '0;
    logic [31:0] got_l = '0;
    logic [15:0] rd;
    int per;

    i2s_port u_i2s_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sdin(sdin), .bclk(bclk), .ws(ws), .sdout(sdout),
        .mclk_out(mclk_out), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: decode frames at bclk rises and score against the queue.
    always @(negedge clk) begin
        if (bclk && !mon_prev_bclk) begin
            mon_sh = {mon_sh[62:0], sdout};
            if (ws && !mon_prev_ws)
                got_l = (mon_w == 32) ? mon_sh[31:0] : {16'h0, mon_sh[15:0]};
            if (!ws && mon_prev_ws && exp_q.size() > 0) begin
                item = exp_q.pop_front();
                chk("R2 serial frame", {got_l, (mon_w == 32) ? mon_sh[31:0] : {16'h0, mon_sh[15:0]}}, item);
            end
            mon_prev_ws = ws;
        end
        mon_prev_bclk = bclk;
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_tx_empty();
        logic [15:0] c;
        do bus_read(3'd0, c); while (c[8]);
    endtask

    task automatic send16(input logic [15:0] l, input logic [15:0] r, input int copies);
        bus_write(3'd1, l); bus_write(3'd2, r);
        for (int i = 0; i < copies; i++) exp_q.push_back({16'h0, l, 16'h0, r});
    endtask

    task automatic measure_bclk(output int n);
        logic p;
        do begin p = bclk; @(negedge clk); end while (!(bclk && !p));
        n = 0;
        do begin p = bclk; @(negedge clk); n++; end while (!(bclk && !p));
    endtask

    task automatic measure_frame(output int n);
        logic pb, pw;
        pw = ws;
        do begin pb = bclk; @(negedge clk);
            if (bclk && !pb) begin if (ws && !pw) break; pw = ws; end
        end while (1);
        n = 0; pw = ws;
        do begin pb = bclk; @(negedge clk);
            if (bclk && !pb) begin n++; if (ws && !pw) break; pw = ws; end
        end while (1);
    endtask

    task automatic wait_queue();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        chk("R4 reset pins", {60'h0, bclk, ws, sdout, irq}, 64'h0);
        bus_read(3'd0, rd);
        chk("R4 reset ctrl", rd, 64'h0);

        // R6 flags set by writes
        bus_write(3'd0, 16'h0020);
        send16(16'h1234, 16'hABCD, 1);
        bus_read(3'd0, rd);
        chk("R6 tx full set", rd, 64'h0320);

        bus_write(3'd0, 16'h0021);
        measure_bclk(per);
        chk("R1 rate 10", per, 64'd2);
        wait_tx_empty();
        send16(16'h8001, 16'h7FFE, 1);
        wait_tx_empty();
        send16(16'h5A5A, 16'hC3C3, 1);
        wait_tx_empty();
        send16(16'hFFFF, 16'h0001, 2);   // R7: repeated after underrun
        wait_tx_empty();
        chk("R11 irq masked", irq, 64'h0);
        wait_queue();
        measure_frame(per);
        chk("R2 frame 16-bit", per, 64'd32);
        bus_read(3'd0, rd);
        chk("R7 underrun set", rd[10], 64'h1);

        // Disable while keeping sticky flags (write 1 to them)
        bus_write(3'd0, 16'h2420);
        mon_prev_ws = 1'b0;
        hi = 1'b0;
        repeat (20) begin @(negedge clk); if (bclk || ws || sdout) hi = 1'b1; end
        chk("R4 idle quiet", hi, 64'h0);
        bus_read(3'd0, rd);
        chk("R7 sticky on write 1", rd[10], 64'h1);
        chk("R8 rx full both", rd[12:11], 64'h3);
        chk("R9 overrun set", rd[13], 64'h1);
        bus_read(3'd1, rd);
        chk("R9 left kept", rd, 64'h1234);
        bus_read(3'd0, rd);
        chk("R8 left read clears left only", rd[12:11], 64'h2);
        bus_read(3'd2, rd);
        chk("R9 right kept", rd, 64'hABCD);
        bus_write(3'd0, 16'h0020);
        bus_read(3'd0, rd);
        chk("R7 R9 cleared by 0", rd, 64'h0020);

        // R5 master clock gating
        bus_write(3'd0, 16'h0022);
        #1 chk("R5 mclk low phase", mclk_out, 64'h0);
        @(posedge clk); #1 chk("R5 mclk high phase", mclk_out, 64'h1);
        bus_write(3'd0, 16'h0020);
        @(posedge clk); #1 chk("R5 mclk gated off", mclk_out, 64'h0);

        // R11 irq and R3 lock
        @(negedge clk);
        bus_write(3'd0, 16'h0025);
        chk("R11 irq on tx empty", irq, 64'h1);
        bus_write(3'd0, 16'h001D);
        bus_read(3'd0, rd);
        chk("R3 width/rate locked", rd[5:3], 64'h4);
        bus_write(3'd0, 16'h0020);
        mon_prev_ws = 1'b0;
        @(negedge clk);
        chk("R11 irq off when disabled", irq, 64'h0);

        // R1 other rate codes
        bus_write(3'd0, 16'h0000); bus_write(3'd0, 16'h0001);
        measure_bclk(per); chk("R1 rate 00", per, 64'd8);
        bus_write(3'd0, 16'h0000); bus_write(3'd0, 16'h0010); bus_write(3'd0, 16'h0011);
        measure_bclk(per); chk("R1 rate 01", per, 64'd4);
        bus_write(3'd0, 16'h0010); bus_write(3'd0, 16'h0030); bus_write(3'd0, 16'h0031);
        measure_bclk(per); chk("R1 rate 11", per, 64'd8);

        // R10 32-bit mode
        bus_write(3'd0, 16'h0030);
        bus_write(3'd0, 16'h0028);
        mon_prev_ws = 1'b0;
        bus_read(3'd1, rd); bus_read(3'd2, rd);
        bus_write(3'd1, 16'hDEAD); bus_write(3'd3, 16'hBEEF);
        bus_write(3'd2, 16'h0123); bus_write(3'd4, 16'h4567);
        exp_q.push_back(64'hDEADBEEF_01234567);
        exp_q.push_back(64'hDEADBEEF_01234567);
        mon_w = 32;
        bus_write(3'd0, 16'h0029);
        wait_queue();
        measure_frame(per);
        chk("R2 frame 32-bit", per, 64'd64);
        bus_write(3'd0, 16'h0028);
        mon_prev_ws = 1'b0;
        bus_read(3'd3, rd); chk("R10 left low", rd, 64'hBEEF);
        bus_read(3'd4, rd); chk("R10 right low", rd, 64'h4567);
        bus_read(3'd1, rd); chk("R10 left high", rd, 64'hDEAD);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule